// File: doc/BRIEF.md
# GPIO input interrupt controller

This block watches a vector of asynchronous pad inputs and turns their activity into interrupts. Each pad passes through a two-stage synchronizer, and the synchronized vector is available to the rest of the chip. For every pin that software has enabled for sampling, four conditions can be armed independently: a rising edge, a falling edge, a high level and a low level. Each armed condition that occurs sets its own sticky status bit for that pin.

Software reads and clears the status through a word-wide register port. The port is reduced to a write strobe with a register select, a word index and 32 data bits, plus a combinational read port addressed the same way. Pins are packed 32 per word, so pin n sits at bit n mod 32 of word n/32. A summary view ORs the four kinds for each pin, and a write of 1 there clears every kind at once. The block drives one global interrupt line and one line per pin. Each can either pulse for one clock per event or stay high while status is pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Each pad input reaches `sync_out` through exactly two flip-flops, so a value applied before clock edge k appears after edge k+1. Select code 11 reads the synchronized vector.
- R2: A pin whose sampling-enable bit (select 1) is 0 raises no status bit and no line activity of any kind.
- R3: With the rising-edge enable (select 2) set, a 0-to-1 change of a sampled pin sets that pin's rising status (select 7).
- R4: With the falling-edge enable (select 3) set, a 1-to-0 change of a sampled pin sets that pin's falling status (select 8).
- R5: High-level (select 4) and low-level (select 5) enables raise an event on every cycle in which the synchronized pin stays at that level. The high status is select 9 and the low status is select 10.
- R6: Writing 1 to a bit of a per-kind status word clears only that kind for that pin. Writing 0 leaves the bit unchanged.
- R7: The summary word (select 6) reads as the OR of the four kinds for each pin. Writing 1 to a summary bit clears all four kinds for that pin.
- R8: When configuration bit 0 (select 0) is 0, `glob_irq` is high for exactly one clock for each cycle in which any enabled event occurs.
- R9: When configuration bit 0 is 1, `glob_irq` stays high while any status bit is pending, and drops once all of them are cleared.
- R10: `pin_irq[n]` pulses one clock per event on pin n when configuration bit 1 is 0. When bit 1 is 1, it stays high until pin n's status is cleared.
- R11: Pin n occupies bit n mod 32 of word n/32 in every per-pin register.
- R12: If an event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R13: Enabling sampling on a pin that is already high creates no rising-edge event.
- R14: The asynchronous active-low reset clears the synchronizer, history, enables, configuration and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| sync_out | output | NUM_PINS | Synchronized pad inputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_word | input | WORD_AW | Word index for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_word | input | WORD_AW | Word index for reads |
| rd_data | output | 32 | Read data (combinational) |
| glob_irq | output | 1 | Global interrupt line |
| pin_irq | output | NUM_PINS | Per-pin interrupt lines |

## Verification
The bench builds the block with NUM_PINS = 40. This gives one full word and one partial word, so the word slicing and the unused upper bits of word 1 are both exercised. With that size, the rising and falling detectors can be swept over every pin one at a time. For each pin, the bench computes the expected status words and pulse counts from the pin index. The level, clear-priority, hold-mode and reset cases then run on chosen pins in both words.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS = 64,
  localparam int WORDS   = (NUM_PINS + 31) / 32,
  localparam int WORD_AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] sync_out,
  input  logic                wr_en,
  input  logic [3:0]          wr_sel,
  input  logic [WORD_AW-1:0]  wr_word,
  input  logic [31:0]         wr_data,
  input  logic [3:0]          rd_sel,
  input  logic [WORD_AW-1:0]  rd_word,
  output logic [31:0]         rd_data,
  output logic                glob_irq,
  output logic [NUM_PINS-1:0] pin_irq
);

  localparam int PW = WORDS * 32;

  localparam logic [3:0] SEL_CFG  = 4'd0;
  localparam logic [3:0] SEL_SAMP = 4'd1;
  localparam logic [3:0] SEL_RISE = 4'd2;
  localparam logic [3:0] SEL_FALL = 4'd3;
  localparam logic [3:0] SEL_HIGH = 4'd4;
  localparam logic [3:0] SEL_LOW  = 4'd5;
  localparam logic [3:0] SEL_SUM  = 4'd6;
  localparam logic [3:0] SEL_SRIS = 4'd7;
  localparam logic [3:0] SEL_SFAL = 4'd8;
  localparam logic [3:0] SEL_SHI  = 4'd9;
  localparam logic [3:0] SEL_SLO  = 4'd10;
  localparam logic [3:0] SEL_SYNC = 4'd11;

  function automatic logic [NUM_PINS-1:0] place(input logic [31:0] d, input logic [WORD_AW-1:0] w);
    logic [PW-1:0] t;
    t = '0;
    if (int'(w) < WORDS) t[int'(w)*32 +: 32] = d;
    return t[NUM_PINS-1:0];
  endfunction

  function automatic logic [31:0] slice(input logic [NUM_PINS-1:0] v, input logic [WORD_AW-1:0] w);
    logic [PW-1:0] t;
    t = '0;
    t[NUM_PINS-1:0] = v;
    if (int'(w) < WORDS) return t[int'(w)*32 +: 32];
    return 32'd0;
  endfunction

  logic [NUM_PINS-1:0] s1, s2, prev;
  logic [NUM_PINS-1:0] en_samp, en_rise, en_fall, en_high, en_low;
  logic [NUM_PINS-1:0] st_rise, st_fall, st_high, st_low;
  logic [NUM_PINS-1:0] pin_ev_q;
  logic                glob_ev_q, glob_held, pin_held;
  logic [1:0]          rst_age;

  wire [NUM_PINS-1:0] wdat  = place(wr_data, wr_word);
  wire [NUM_PINS-1:0] wmask = place(32'hFFFF_FFFF, wr_word);

  wire [NUM_PINS-1:0] ev_rise = en_samp & en_rise & s2 & ~prev;
  wire [NUM_PINS-1:0] ev_fall = en_samp & en_fall & ~s2 & prev;
  wire [NUM_PINS-1:0] ev_high = en_samp & en_high & s2;
  wire [NUM_PINS-1:0] ev_low  = en_samp & en_low & ~s2;
  wire [NUM_PINS-1:0] ev_any  = ev_rise | ev_fall | ev_high | ev_low;

  wire [NUM_PINS-1:0] clr_all  = (wr_en && wr_sel == SEL_SUM)  ? wdat : '0;
  wire [NUM_PINS-1:0] clr_rise = clr_all | ((wr_en && wr_sel == SEL_SRIS) ? wdat : '0);
  wire [NUM_PINS-1:0] clr_fall = clr_all | ((wr_en && wr_sel == SEL_SFAL) ? wdat : '0);
  wire [NUM_PINS-1:0] clr_high = clr_all | ((wr_en && wr_sel == SEL_SHI)  ? wdat : '0);
  wire [NUM_PINS-1:0] clr_low  = clr_all | ((wr_en && wr_sel == SEL_SLO)  ? wdat : '0);

  wire [NUM_PINS-1:0] summary = st_rise | st_fall | st_high | st_low;

  assign sync_out = s2;
  assign glob_irq = glob_held ? |summary : glob_ev_q;
  assign pin_irq  = pin_held ? summary : pin_ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      prev    <= '0;
      rst_age <= '0;
    end else begin
      s1   <= pad_in;
      s2   <= s1;
      prev <= s2;
      if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_samp   <= '0;
      en_rise   <= '0;
      en_fall   <= '0;
      en_high   <= '0;
      en_low    <= '0;
      glob_held <= 1'b0;
      pin_held  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CFG:  {pin_held, glob_held} <= wr_data[1:0];
        SEL_SAMP: en_samp <= (en_samp & ~wmask) | wdat;
        SEL_RISE: en_rise <= (en_rise & ~wmask) | wdat;
        SEL_FALL: en_fall <= (en_fall & ~wmask) | wdat;
        SEL_HIGH: en_high <= (en_high & ~wmask) | wdat;
        SEL_LOW:  en_low  <= (en_low & ~wmask) | wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rise   <= '0;
      st_fall   <= '0;
      st_high   <= '0;
      st_low    <= '0;
      pin_ev_q  <= '0;
      glob_ev_q <= 1'b0;
    end else begin
      st_rise   <= (st_rise & ~clr_rise) | ev_rise;
      st_fall   <= (st_fall & ~clr_fall) | ev_fall;
      st_high   <= (st_high & ~clr_high) | ev_high;
      st_low    <= (st_low & ~clr_low) | ev_low;
      pin_ev_q  <= ev_any;
      glob_ev_q <= |ev_any;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CFG:  rd_data = {30'd0, pin_held, glob_held};
      SEL_SAMP: rd_data = slice(en_samp, rd_word);
      SEL_RISE: rd_data = slice(en_rise, rd_word);
      SEL_FALL: rd_data = slice(en_fall, rd_word);
      SEL_HIGH: rd_data = slice(en_high, rd_word);
      SEL_LOW:  rd_data = slice(en_low, rd_word);
      SEL_SUM:  rd_data = slice(summary, rd_word);
      SEL_SRIS: rd_data = slice(st_rise, rd_word);
      SEL_SFAL: rd_data = slice(st_fall, rd_word);
      SEL_SHI:  rd_data = slice(st_high, rd_word);
      SEL_SLO:  rd_data = slice(st_low, rd_word);
      SEL_SYNC: rd_data = slice(s2, rd_word);
      default:  rd_data = 32'd0;
    endcase
  end

  p_sync_two_flops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_age == 2'd3) |-> (sync_out == $past(pad_in, 2)));

  p_off_pin_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(en_samp) & ~$past(summary) & summary) == '0));

  p_kind_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_rise & ~ev_rise) & st_rise) == '0));

  p_event_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ev_high) & ~st_high) == '0) && (($past(ev_low) & ~st_low) == '0));

  p_glob_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_held && $past(glob_held) && $past(glob_irq) &&
     ($past(clr_rise | clr_fall | clr_high | clr_low) == '0)) |-> glob_irq);

  p_pin_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_held |-> ((pin_irq & ~$past(ev_any)) == '0));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  sync_out;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_sel = '0;
  logic [0:0]    wr_word = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    rd_sel = '0;
  logic [0:0]    rd_word = '0;
  logic [31:0]   rd_data;
  logic          glob_irq;
  logic [N-1:0]  pin_irq;

  int total = 0;
  int bad = 0;
  int gc, pc;
  logic [31:0] v;
  logic [N-1:0] ALL = '1;

  gpio_irq_ctrl #(.NUM_PINS(N)) u_gpio_irq_ctrl (
    .clk, .rst_n, .pad_in, .sync_out, .wr_en, .wr_sel, .wr_word, .wr_data,
    .rd_sel, .rd_word, .rd_data, .glob_irq, .pin_irq);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input int w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_word = w[0:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, input int w, output logic [31:0] d);
    rd_sel = s; rd_word = w[0:0];
    #0.5;
    d = rd_data;
  endtask

  task automatic run(input int n, input int pin);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      gc += int'(glob_irq);
      pc += int'(pin_irq[pin]);
    end
  endtask

  function automatic logic [31:0] bitw(input int p, input int w);
    return (p / 32 == w) ? (32'd1 << (p % 32)) : 32'd0;
  endfunction

  initial begin
    #1ms;
    total++; bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R14 reset glob", glob_irq, 0);
    chk("R14 reset pins", pin_irq, 0);
    rst_n = 1'b1;
    rd(4'd6, 0, v); chk("R14 reset summary", v, 0);

    @(negedge clk); pad_in = 40'hA5_5A3C_C3F0;
    @(negedge clk);
    rd(4'd11, 0, v); chk("R1 one edge not through", v, 0);
    @(negedge clk);
    rd(4'd11, 0, v); chk("R1 sync word0", v, 32'h5A3C_C3F0);
    rd(4'd11, 1, v); chk("R1 sync word1 R11", v, 32'hA5);
    chk("R1 sync port", sync_out, 40'hA5_5A3C_C3F0);
    @(negedge clk); pad_in = '0;
    repeat (4) @(negedge clk);

    wr(4'd1, 0, 32'hFFFF_FFFF); wr(4'd1, 1, 32'hFF);
    wr(4'd2, 0, 32'hFFFF_FFFF); wr(4'd2, 1, 32'hFF);
    for (int p = 0; p < N; p++) begin
      gc = 0; pc = 0;
      @(negedge clk); pad_in = ALL & (40'd1 << p);
      run(6, p);
      chk($sformatf("R8 rise glob pulse pin%0d", p), gc, 1);
      chk($sformatf("R10 rise pin pulse pin%0d", p), pc, 1);
      for (int w = 0; w < 2; w++) begin
        rd(4'd7, w, v); chk($sformatf("R3 R11 rise status pin%0d w%0d", p, w), v, bitw(p, w));
      end
      wr(4'd6, p / 32, 32'd1 << (p % 32));
      rd(4'd6, p / 32, v); chk($sformatf("R7 summary clear pin%0d", p), v, 0);
      gc = 0;
      @(negedge clk); pad_in = '0;
      run(6, p);
      chk($sformatf("R3 no event on fall pin%0d", p), gc, 0);
    end

    wr(4'd2, 0, 0); wr(4'd2, 1, 0);
    wr(4'd3, 0, 32'hFFFF_FFFF); wr(4'd3, 1, 32'hFF);
    @(negedge clk); pad_in = ALL;
    gc = 0; run(6, 0);
    chk("R4 no event on rise", gc, 0);
    for (int p = 0; p < N; p++) begin
      gc = 0; pc = 0;
      @(negedge clk); pad_in = ALL & ~(40'd1 << p);
      run(6, p);
      chk($sformatf("R8 fall glob pulse pin%0d", p), gc, 1);
      for (int w = 0; w < 2; w++) begin
        rd(4'd8, w, v); chk($sformatf("R4 R11 fall status pin%0d w%0d", p, w), v, bitw(p, w));
      end
      wr(4'd8, p / 32, 32'd1 << (p % 32));
      rd(4'd8, p / 32, v); chk($sformatf("R6 fall clear pin%0d", p), v, 0);
      @(negedge clk); pad_in = ALL;
      run(6, p);
    end
    wr(4'd3, 0, 0); wr(4'd3, 1, 0);
    @(negedge clk); pad_in = '0;
    repeat (4) @(negedge clk);

    wr(4'd1, 0, ~(32'd1 << 5));
    wr(4'd2, 0, 32'd1 << 5); wr(4'd4, 0, 32'd1 << 5);
    gc = 0;
    @(negedge clk); pad_in = 40'd1 << 5; run(6, 5);
    @(negedge clk); pad_in = '0; run(6, 5);
    chk("R2 disabled pin no glob", gc, 0);
    rd(4'd6, 0, v); chk("R2 disabled pin no status", v, 0);

    wr(4'd4, 0, 0); wr(4'd2, 0, 32'd1 << 6);
    wr(4'd1, 0, ~(32'd1 << 6));
    @(negedge clk); pad_in = 40'd1 << 6; run(6, 6);
    gc = 0;
    wr(4'd1, 0, 32'hFFFF_FFFF);
    run(6, 6);
    chk("R13 enable while high no glob", gc, 0);
    rd(4'd7, 0, v); chk("R13 enable while high no rise", v, 0);
    wr(4'd2, 0, 0);
    @(negedge clk); pad_in = '0; repeat (4) @(negedge clk);

    wr(4'd4, 0, 32'd1 << 3);
    gc = 0; pc = 0;
    @(negedge clk); pad_in = 40'd1 << 3; run(10, 3);
    @(negedge clk); pad_in = '0; run(7, 3);
    chk("R5 high level pin pulses", pc, 10);
    chk("R8 high level glob pulses", gc, 10);
    rd(4'd9, 0, v); chk("R5 high status", v, 32'd1 << 3);
    wr(4'd4, 0, 0); wr(4'd9, 0, 32'd1 << 3);
    rd(4'd9, 0, v); chk("R6 high clear", v, 0);
    wr(4'd5, 0, 32'd1 << 4);
    run(4, 4);
    rd(4'd10, 0, v); chk("R5 low status", v, 32'd1 << 4);
    wr(4'd5, 0, 0); wr(4'd10, 0, 32'd1 << 4);
    rd(4'd10, 0, v); chk("R6 low clear", v, 0);

    wr(4'd2, 0, 32'd1 << 3); wr(4'd4, 0, 32'd1 << 3);
    @(negedge clk); pad_in = 40'd1 << 3; run(6, 3);
    wr(4'd4, 0, 0);
    @(negedge clk); pad_in = '0; run(6, 3);
    wr(4'd9, 0, 0);
    rd(4'd9, 0, v); chk("R6 write zero keeps", v, 32'd1 << 3);
    wr(4'd7, 0, 32'd1 << 3);
    rd(4'd7, 0, v); chk("R6 rise cleared", v, 0);
    rd(4'd9, 0, v); chk("R6 high kept", v, 32'd1 << 3);
    rd(4'd6, 0, v); chk("R7 summary or", v, 32'd1 << 3);
    wr(4'd6, 0, 32'd1 << 3);
    rd(4'd9, 0, v); chk("R7 summary clears high", v, 0);
    wr(4'd2, 0, 0);

    wr(4'd0, 0, 32'd3);
    rd(4'd0, 0, v); chk("R9 cfg readback", v, 3);
    wr(4'd2, 1, 32'd1 << 3);
    @(negedge clk); pad_in = 40'd1 << 35; run(20, 35);
    chk("R9 glob held", glob_irq, 1);
    chk("R10 pin held", pin_irq[35], 1);
    rd(4'd7, 1, v); chk("R11 pin35 word1", v, 32'd1 << 3);
    rd(4'd7, 0, v); chk("R11 pin35 not word0", v, 0);
    wr(4'd7, 1, 32'd1 << 3);
    chk("R9 glob drops after clear", glob_irq, 0);
    chk("R10 pin drops after clear", pin_irq, 0);
    wr(4'd0, 0, 0); wr(4'd2, 1, 0);
    @(negedge clk); pad_in = '0; repeat (4) @(negedge clk);

    wr(4'd4, 0, 32'd1 << 2);
    @(negedge clk); pad_in = 40'd1 << 2; run(6, 2);
    wr(4'd9, 0, 32'd1 << 2);
    rd(4'd9, 0, v); chk("R12 event beats clear", v, 32'd1 << 2);
    wr(4'd4, 0, 0);
    @(negedge clk); pad_in = '0; run(4, 2);
    wr(4'd9, 0, 32'd1 << 2);
    rd(4'd9, 0, v); chk("R12 clear once quiet", v, 0);

    wr(4'd2, 0, 1);
    @(negedge clk); pad_in = 40'd1; run(6, 0);
    rd(4'd7, 0, v); chk("R14 pending before reset", v, 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    rd(4'd6, 0, v); chk("R14 status cleared", v, 0);
    rd(4'd2, 0, v); chk("R14 enable cleared", v, 0);
    chk("R14 sync cleared", sync_out, 0);
    @(negedge clk); rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule